// File: doc/BRIEF.md
# USB Load Switch Fault and Thermal Controller

This block is the digital control for a current-limited USB power switch. It takes the switch enable, an over-current comparator output and two temperature comparator flags: one that rises above the trip point and one that falls below the release point. From these it produces a gate-on request for the power device, an output-discharge request, and an active-low fault flag meant to drive an open-drain pad. Every timer advances on a one-microsecond tick strobe supplied from outside, so the delay parameters are written in microseconds.

Turning the switch on or off follows a fixed delay after the enable changes. While the switch is in current limit it stays on. Only the fault flag responds, and it is filtered with the same long window for assertion and release. An over-temperature event works on a separate path. It opens the switch and flags a fault at once. The trip is held until the release comparator reports that the die has cooled, and the switch then comes back through its normal turn-on delay if it is still enabled. This block acts only on the switch, so other supply rails keep running through a thermal event.

Top module: `usb_sw_guard`

## Requirements
- R1: After reset, `gate_on` is 0, `dis_on` is 1 and `fault_n` is 1.
- R2: Once `sw_en` is sampled high from idle, `gate_on` rises only after `TON_US` ticks have elapsed. It is 0 at every cycle before that.
- R3: When `sw_en` is sampled low with the switch on, `gate_on` stays 1 for `TOFF_US` ticks and then drops to 0.
- R4: `dis_on` is 1 exactly when the switch is idle (fully off). It is 0 during the turn-on delay, while on, and during the turn-off delay.
- R5: With the switch enabled, `fault_n` goes low only after `oc_hit` has been 1 for `OC_US` consecutive ticks. A shorter burst leaves `fault_n` at 1.
- R6: Once the over-current fault is flagged, `fault_n` returns to 1 only after `oc_hit` has been 0 for `OC_US` consecutive ticks. A shorter gap leaves it low.
- R7: An over-current, whether filtered or not, does not change `gate_on`.
- R8: A cycle with `temp_hot` = 1 drives `fault_n` low on the next cycle. It forces `gate_on` to 0 and `dis_on` to 1 within two cycles.
- R9: The thermal trip is held after `temp_hot` falls until `temp_cool` = 1 is seen. If both flags are 1, the trip wins. When the trip clears, `fault_n` rises if no over-current fault is flagged, and an enabled switch turns back on through the R2 delay. A disabled switch stays off.
- R10: While `sw_en` is 0, the over-current filter is held clear, so `fault_n` is 1 one cycle later unless a thermal trip is in force.
- R11: `sw_en` falling during the turn-on delay returns the switch to idle without ever raising `gate_on`. `sw_en` rising during the turn-off delay keeps `gate_on` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| sw_en | input | 1 | Switch enable, synchronous to clk |
| oc_hit | input | 1 | Over-current comparator flag |
| temp_hot | input | 1 | Die above thermal trip point |
| temp_cool | input | 1 | Die below thermal release point |
| gate_on | output | 1 | Request to turn the pass device on |
| dis_on | output | 1 | Request to engage the output discharge path |
| fault_n | output | 1 | Fault flag, active low, for an open-drain driver |

## Verification
The assertions assume that every input is already synchronous to `clk` and that `tick_us` is a single-cycle strobe. They also assume that `temp_hot` and `temp_cool` may both be high, and that in this case the trip takes precedence. The bench drives every input on the falling clock edge. It generates the tick as a strobe on every other cycle, so that tick gating is exercised. It overrides the delay parameters with small values. All timing checks are placed a few cycles before and after the expected tick boundary, which keeps the stimulus away from the exact edge where the window closes.

// File: rtl/usb_sw_pkg.sv
`timescale 1ns/1ps
package usb_sw_pkg;
  typedef enum logic [1:0] {
    SW_IDLE     = 2'd0,
    SW_RAMP_ON  = 2'd1,
    SW_CLOSED   = 2'd2,
    SW_RAMP_OFF = 2'd3
  } sw_state_e;
endpackage

// File: rtl/usw_tick_timer.sv
`timescale 1ns/1ps
module usw_tick_timer #(
  parameter int unsigned LIMIT = 1100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run && tick && (cnt_q != LIM))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIM);

  // R2: the count never passes its limit
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  // R2: without a tick the count holds
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/usw_oc_filter.sv
`timescale 1ns/1ps
module usw_oc_filter #(
  parameter int unsigned OC_US = 8800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic raw,
  output logic flt
);
  localparam int unsigned W = $clog2(OC_US + 1);
  localparam logic [W-1:0] LAST = W'(OC_US - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         flt_q, flt_d;

  always_comb begin
    cnt_d = cnt_q;
    flt_d = flt_q;
    if (clr) begin
      cnt_d = '0;
      flt_d = 1'b0;
    end else if (raw == flt_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        flt_d = ~flt_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign flt = flt_q;

  // R5: the flag only sets while the comparator reads over-current
  a_r5_set_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q) |-> $past(raw));
  // R6: the flag only clears on a clean comparator or a forced clear
  a_r6_release_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_q) |-> (!$past(raw) || $past(clr)));
  // R10: a forced clear empties the filter
  a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!flt_q && cnt_q == '0));
endmodule

// File: rtl/usw_thermal.sv
`timescale 1ns/1ps
module usw_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic cool,
  output logic trip
);
  logic trip_q, trip_d;

  always_comb begin
    trip_d = trip_q;
    if (hot)       trip_d = 1'b1;
    else if (cool) trip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= trip_d;
  end

  assign trip = trip_q;

  // R8: a hot reading always sets the trip
  a_r8_hot_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> trip_q);
  // R9: the trip only clears after a cool reading without a hot one
  a_r9_release_needs_cool: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_q) |-> ($past(cool) && !$past(hot)));
endmodule

// File: rtl/usw_power_fsm.sv
`timescale 1ns/1ps
module usw_power_fsm
  import usb_sw_pkg::*;
#(
  parameter int unsigned TON_US  = 1100,
  parameter int unsigned TOFF_US = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic trip,
  output logic gate,
  output logic dis
);
  sw_state_e state_q, state_d;
  logic      on_done, off_done, step;

  always_comb begin
    state_d = state_q;
    if (trip) begin
      state_d = SW_IDLE;
    end else begin
      unique case (state_q)
        SW_IDLE:     if (en) state_d = SW_RAMP_ON;
        SW_RAMP_ON:  if (!en) state_d = SW_IDLE;
                     else if (on_done) state_d = SW_CLOSED;
        SW_CLOSED:   if (!en) state_d = SW_RAMP_OFF;
        SW_RAMP_OFF: if (en) state_d = SW_CLOSED;
                     else if (off_done) state_d = SW_IDLE;
        default:     state_d = SW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SW_IDLE;
    else        state_q <= state_d;
  end

  assign step = (state_d != state_q);

  usw_tick_timer #(.LIMIT(TON_US)) u_on_tmr (
    .clk(clk), .rst_n(rst_n), .clr(step),
    .run(state_q == SW_RAMP_ON), .tick(tick), .done(on_done)
  );

  usw_tick_timer #(.LIMIT(TOFF_US)) u_off_tmr (
    .clk(clk), .rst_n(rst_n), .clr(step),
    .run(state_q == SW_RAMP_OFF), .tick(tick), .done(off_done)
  );

  assign gate = (state_q == SW_CLOSED) || (state_q == SW_RAMP_OFF);
  assign dis  = (state_q == SW_IDLE);

  // R8: a thermal trip empties the state machine on the next edge
  a_r8_trip_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (state_q == SW_IDLE));
  // R2: closing from the ramp requires the enable and the full delay
  a_r2_close_needs_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_RAMP_ON && state_d == SW_CLOSED) |-> (en && on_done));
  // R11: dropping the enable mid-ramp returns to idle
  a_r11_abort_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_RAMP_ON && !en && !trip) |=> (state_q == SW_IDLE));
  // R3: opening the switch after the enable drops waits for the off delay
  a_r3_open_needs_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate) && !$past(trip)) |-> $past(off_done));
endmodule

// File: rtl/usb_sw_guard.sv
`timescale 1ns/1ps
module usb_sw_guard #(
  parameter int unsigned OC_US   = 8800,
  parameter int unsigned TON_US  = 1100,
  parameter int unsigned TOFF_US = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic sw_en,
  input  logic oc_hit,
  input  logic temp_hot,
  input  logic temp_cool,
  output logic gate_on,
  output logic dis_on,
  output logic fault_n
);
  logic oc_flt;
  logic th_trip;

  usw_thermal u_thermal (
    .clk(clk), .rst_n(rst_n), .hot(temp_hot), .cool(temp_cool), .trip(th_trip)
  );

  usw_oc_filter #(.OC_US(OC_US)) u_oc (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .clr(!sw_en),
    .raw(oc_hit), .flt(oc_flt)
  );

  usw_power_fsm #(.TON_US(TON_US), .TOFF_US(TOFF_US)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .en(sw_en), .trip(th_trip),
    .gate(gate_on), .dis(dis_on)
  );

  assign fault_n = ~(oc_flt | th_trip);

  // R7: over-current alone never opens a closed switch
  a_r7_oc_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && sw_en && !th_trip) |=> gate_on);
  // R4: the gate request and the discharge request never overlap
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_on && dis_on));
  // R10: a disabled switch without a trip shows no fault one cycle on
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && !temp_hot) |=> (fault_n || th_trip));
endmodule

// File: tb/usb_sw_guard_bench.sv
`timescale 1ns/1ps
module usb_sw_guard_bench;
  localparam int unsigned OC   = 40;
  localparam int unsigned TON  = 11;
  localparam int unsigned TOFF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic sw_en = 1'b0, oc_hit = 1'b0, temp_hot = 1'b0, temp_cool = 1'b0;
  logic gate_on, dis_on, fault_n;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) tick_us <= rst_n ? ~tick_us : 1'b0;

  usb_sw_guard #(.OC_US(OC), .TON_US(TON), .TOFF_US(TOFF)) u_usb_sw_guard (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .sw_en(sw_en),
    .oc_hit(oc_hit), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .gate_on(gate_on), .dis_on(dis_on), .fault_n(fault_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 gate_on", gate_on, 1'b0);
    chk("R1 dis_on", dis_on, 1'b1);
    chk("R1 fault_n", fault_n, 1'b1);
  endtask

  task automatic t_turn_on();
    sw_en = 1'b1;
    cyc(3);
    chk("R4 dis_on off in ramp", dis_on, 1'b0);
    cyc(15);
    chk("R2 gate_on still low", gate_on, 1'b0);
    cyc(10);
    chk("R2 gate_on high", gate_on, 1'b1);
    chk("R4 dis_on off when on", dis_on, 1'b0);
  endtask

  task automatic t_overcurrent();
    oc_hit = 1'b1; cyc(40); oc_hit = 1'b0; cyc(100);
    chk("R5 short burst ignored", fault_n, 1'b1);
    oc_hit = 1'b1; cyc(70);
    chk("R5 not yet flagged", fault_n, 1'b1);
    cyc(20);
    chk("R5 flagged", fault_n, 1'b0);
    chk("R7 gate stays on", gate_on, 1'b1);
    oc_hit = 1'b0; cyc(30); oc_hit = 1'b1; cyc(10); oc_hit = 1'b0;
    chk("R6 short gap holds flag", fault_n, 1'b0);
    cyc(70);
    chk("R6 not yet released", fault_n, 1'b0);
    cyc(20);
    chk("R6 released", fault_n, 1'b1);
    chk("R7 gate still on", gate_on, 1'b1);
  endtask

  task automatic t_disable_clears();
    oc_hit = 1'b1; cyc(90);
    chk("R5 flag before disable", fault_n, 1'b0);
    sw_en = 1'b0; cyc(2);
    chk("R10 flag released", fault_n, 1'b1);
    cyc(18);
    chk("R3 gate held in off delay", gate_on, 1'b1);
    chk("R4 no discharge in off delay", dis_on, 1'b0);
    cyc(20);
    chk("R3 gate off", gate_on, 1'b0);
    chk("R4 discharge when idle", dis_on, 1'b1);
    cyc(80);
    chk("R10 flag stays clear while off", fault_n, 1'b1);
    oc_hit = 1'b0;
  endtask

  task automatic t_abort_and_resume();
    sw_en = 1'b1; cyc(10); sw_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gate_on !== 1'b0) begin
        chk("R11 no gate on aborted ramp", gate_on, 1'b0);
        break;
      end
    end
    chk("R11 idle after abort", dis_on, 1'b1);
    sw_en = 1'b1; cyc(30);
    chk("R2 on after full delay", gate_on, 1'b1);
    sw_en = 1'b0; cyc(10); sw_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gate_on !== 1'b1) begin
        chk("R11 gate kept on re-enable", gate_on, 1'b1);
        break;
      end
    end
    chk("R11 gate on after re-enable", gate_on, 1'b1);
  endtask

  task automatic t_thermal_enabled();
    temp_hot = 1'b1; cyc(1); temp_hot = 1'b0;
    chk("R8 fault immediate", fault_n, 1'b0);
    cyc(2);
    chk("R8 gate forced off", gate_on, 1'b0);
    chk("R8 discharge on", dis_on, 1'b1);
    cyc(50);
    chk("R9 trip held", fault_n, 1'b0);
    chk("R9 stays off while hot", gate_on, 1'b0);
    temp_hot = 1'b1; temp_cool = 1'b1; cyc(3);
    chk("R9 hot wins over cool", fault_n, 1'b0);
    temp_hot = 1'b0; cyc(3); temp_cool = 1'b0;
    chk("R9 released on cool", fault_n, 1'b1);
    cyc(12);
    chk("R9 restart waits delay", gate_on, 1'b0);
    cyc(15);
    chk("R9 restarted", gate_on, 1'b1);
  endtask

  task automatic t_thermal_disabled();
    sw_en = 1'b0; cyc(40);
    chk("R3 off before trip", gate_on, 1'b0);
    temp_hot = 1'b1; cyc(1); temp_hot = 1'b0; cyc(30);
    chk("R10 trip keeps fault while disabled", fault_n, 1'b0);
    temp_cool = 1'b1; cyc(2); temp_cool = 1'b0;
    chk("R9 fault clears", fault_n, 1'b1);
    cyc(40);
    chk("R9 disabled stays off", gate_on, 1'b0);
    chk("R9 disabled discharge", dis_on, 1'b1);
  endtask

  initial begin
    cyc(3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_turn_on();
    t_overcurrent();
    t_disable_clears();
    t_abort_and_resume();
    t_thermal_enabled();
    t_thermal_disabled();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule